// File: doc/BRIEF.md
# ECC Error Capture Register

This block sits beside the read path of a memory controller and keeps a record of the first ECC event that the path reports. The path gives two strobes: one for a read whose single-bit error was corrected, one for a read with an uncorrectable multi-bit error. Each strobe comes with the failing address and the 8-bit syndrome. On the first event the block stores the error type, the top 19 address bits and the syndrome. It then freezes that record until software clears it.

Software sees one 32-bit register through a plain write strobe and a read bus that is always valid. Bit 31 turns hardware scrubbing off. Bits 30:12 hold the captured address bits and bits 11:4 hold the captured syndrome; both fields are read-only. Bit 3 enables the system-error output and bit 2 enables the NMI output. Bit 1 flags a multi-bit record and bit 0 flags a single-bit record; software clears them by writing 1.

While scrubbing is on, the block sends a one-cycle request for every corrected read, so the corrected data can be written back to memory.

Top module: `ecc_error_capture_reg`

## Requirements
- R1: After reset the read bus shows 0 and nmi_out, serr_out and scrub_req are low.
- R2: A write stores bit 31 (scrub disable), bit 3 (system-error enable) and bit 2 (NMI enable) into the register, and they read back on the next cycle. A write to bits 30:4 has no effect on those bits.
- R3: With no record held, a corrected-error strobe sets bit 0 on the next cycle. In the same cycle, bits 30:12 take address bits [ADDR_W-1:ADDR_W-19] and bits 11:4 take the corrected-error syndrome.
- R4: With no record held, an uncorrectable-error strobe sets bit 1 on the next cycle and captures the uncorrectable-error address and syndrome into the same fields.
- R5: If both strobes arrive in the same cycle with no record held, only the multi-bit error is recorded: bit 1 sets, bit 0 stays 0, and the fields take the uncorrectable-error address and syndrome. Bits 1:0 never read 11.
- R6: While bit 0 or bit 1 is set, new strobes change neither the status bits nor the address and syndrome fields.
- R7: A write with wr_data bits 1 and 0 both equal to 1 clears both status bits. A write with only one of them set, or neither, leaves the status bits unchanged.
- R8: A strobe in the same cycle as a clearing write is not recorded. A strobe in the next cycle is recorded.
- R9: nmi_out is high exactly when bit 0 and bit 2 are both set. serr_out is high exactly when bit 1 and bit 3 are both set. Both are levels.
- R10: scrub_req pulses for one cycle, one cycle after each corrected-error strobe, whenever bit 31 was 0 in the strobe's cycle. This happens whether or not a record is held. When bit 31 is 1, no pulse is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_stb | input | 1 | Corrected single-bit error seen on a read |
| ce_addr | input | ADDR_W | Address of the corrected read |
| ce_syn | input | 8 | Syndrome of the corrected read |
| ue_stb | input | 1 | Uncorrectable multi-bit error seen on a read |
| ue_addr | input | ADDR_W | Address of the failing read |
| ue_syn | input | 8 | Syndrome of the failing read |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents |
| nmi_out | output | 1 | Single-bit error interrupt level |
| serr_out | output | 1 | Multi-bit error system-error level |
| scrub_req | output | 1 | One-cycle request to write back corrected data |

## Verification
The hardest state to reach is the one where a record is freed and a new strobe arrives in that same cycle. Reaching it needs a held record, a clearing write and a strobe to line up on one edge. The bench drives them together on purpose. It also drives both strobes together with the record empty, and a partial clear followed by a strobe, to cover the first-come and two-bit-clear rules. A long phase of random stimulus follows. In that phase a cycle model is compared against the design field by field on every clock.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

  localparam int REG_W      = 32;
  localparam int ADDR_FLD_W = 19;
  localparam int SYN_W      = 8;

  // bit positions decoded by software
  localparam int BIT_SBE       = 0;
  localparam int BIT_MBE       = 1;
  localparam int BIT_NMI_EN    = 2;
  localparam int BIT_SERR_EN   = 3;
  localparam int SYN_LSB       = 4;
  localparam int ADDR_LSB      = 12;
  localparam int BIT_SCRUB_DIS = 31;

  typedef enum logic [1:0] {
    EVT_NONE = 2'b00,
    EVT_CE   = 2'b01,
    EVT_UE   = 2'b10
  } evt_kind_e;

  typedef struct packed {
    logic scrub_dis;
    logic serr_en;
    logic nmi_en;
  } ctrl_t;

  typedef struct packed {
    logic                  mbe;
    logic                  sbe;
    logic [ADDR_FLD_W-1:0] addr;
    logic [SYN_W-1:0]      syn;
  } rec_t;

  // both status bits must be written as one to release the record
  function automatic logic is_full_clear(input logic wr, input logic [REG_W-1:0] d);
    return wr & d[BIT_SBE] & d[BIT_MBE];
  endfunction

  function automatic ctrl_t ctrl_from_write(input logic [REG_W-1:0] d);
    ctrl_t c;
    c.scrub_dis = d[BIT_SCRUB_DIS];
    c.serr_en   = d[BIT_SERR_EN];
    c.nmi_en    = d[BIT_NMI_EN];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] pack_view(input ctrl_t c, input rec_t r);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_SCRUB_DIS]                     = c.scrub_dis;
    v[ADDR_LSB +: ADDR_FLD_W]            = r.addr;
    v[SYN_LSB +: SYN_W]                  = r.syn;
    v[BIT_SERR_EN]                       = c.serr_en;
    v[BIT_NMI_EN]                        = c.nmi_en;
    v[BIT_MBE]                           = r.mbe;
    v[BIT_SBE]                           = r.sbe;
    return v;
  endfunction

endpackage

// File: rtl/ecc_evt_select.sv
module ecc_evt_select
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  ce_stb,
  input  logic [ADDR_W-1:0]     ce_addr,
  input  logic [SYN_W-1:0]      ce_syn,
  input  logic                  ue_stb,
  input  logic [ADDR_W-1:0]     ue_addr,
  input  logic [SYN_W-1:0]      ue_syn,
  output evt_kind_e             kind,
  output logic [ADDR_FLD_W-1:0] addr_fld,
  output logic [SYN_W-1:0]      syn
);

  localparam int TOP = ADDR_W - 1;

  logic [ADDR_FLD_W-1:0] ce_fld;
  logic [ADDR_FLD_W-1:0] ue_fld;

  generate
    if (ADDR_W >= ADDR_FLD_W) begin : g_slice
      assign ce_fld = ce_addr[TOP -: ADDR_FLD_W];
      assign ue_fld = ue_addr[TOP -: ADDR_FLD_W];
    end else begin : g_pad
      assign ce_fld = {ce_addr, {(ADDR_FLD_W-ADDR_W){1'b0}}};
      assign ue_fld = {ue_addr, {(ADDR_FLD_W-ADDR_W){1'b0}}};
    end
  endgenerate

  // multi-bit error wins a tie
  always_comb begin
    if (ue_stb) begin
      kind     = EVT_UE;
      addr_fld = ue_fld;
      syn      = ue_syn;
    end else if (ce_stb) begin
      kind     = EVT_CE;
      addr_fld = ce_fld;
      syn      = ce_syn;
    end else begin
      kind     = EVT_NONE;
      addr_fld = '0;
      syn      = '0;
    end
  end

endmodule

// File: rtl/ecc_ctrl_bits.sv
module ecc_ctrl_bits
  import ecc_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= ctrl_from_write(wr_data);
  end

  assign ctrl = ctrl_q;

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl.scrub_dis == $past(wr_data[BIT_SCRUB_DIS]))
           && (ctrl.nmi_en == $past(wr_data[BIT_NMI_EN]))
           && (ctrl.serr_en == $past(wr_data[BIT_SERR_EN])));

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl));

endmodule

// File: rtl/ecc_record.sv
module ecc_record
  import ecc_cap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  evt_kind_e             kind,
  input  logic [ADDR_FLD_W-1:0] addr_fld,
  input  logic [SYN_W-1:0]      syn,
  input  logic                  clr,
  output rec_t                  rec,
  output logic                  held,
  output logic                  capture
);

  rec_t rec_q;

  assign held    = rec_q.sbe | rec_q.mbe;
  assign capture = (kind != EVT_NONE) & ~held & ~clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (clr) begin
      rec_q.sbe <= 1'b0;
      rec_q.mbe <= 1'b0;
    end else if (capture) begin
      rec_q.sbe  <= (kind == EVT_CE);
      rec_q.mbe  <= (kind == EVT_UE);
      rec_q.addr <= addr_fld;
      rec_q.syn  <= syn;
    end
  end

  assign rec = rec_q;

  assert_one_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec.mbe, rec.sbe}));

  assert_ue_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && !clr && kind == EVT_UE) |=> (rec.mbe && !rec.sbe));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !clr) |=> ($stable(rec.addr) && $stable(rec.syn)
                        && $stable(rec.sbe) && $stable(rec.mbe)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rec.sbe && !rec.mbe));

  assert_clear_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && kind != EVT_NONE) |=> !held);

endmodule

// File: rtl/ecc_scrub_pulse.sv
module ecc_scrub_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_stb,
  input  logic scrub_dis,
  output logic scrub_req
);

  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= ce_stb & ~scrub_dis;
  end

  assign scrub_req = req_q;

  assert_scrub_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_stb && !scrub_dis) |=> scrub_req);

  assert_scrub_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_stb || scrub_dis) |=> !scrub_req);

endmodule

// File: rtl/ecc_error_capture_reg.sv
module ecc_error_capture_reg
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_stb,
  input  logic [ADDR_W-1:0] ce_addr,
  input  logic [7:0]        ce_syn,
  input  logic              ue_stb,
  input  logic [ADDR_W-1:0] ue_addr,
  input  logic [7:0]        ue_syn,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              nmi_out,
  output logic              serr_out,
  output logic              scrub_req
);

  evt_kind_e             evt_kind;
  logic [ADDR_FLD_W-1:0] evt_addr;
  logic [SYN_W-1:0]      evt_syn;
  logic                  clr_req;
  logic                  rec_held;
  logic                  rec_capture;
  ctrl_t                 ctrl;
  rec_t                  rec;

  assign clr_req = is_full_clear(wr_en, wr_data);

  ecc_evt_select #(.ADDR_W(ADDR_W)) u_sel (
    .ce_stb   (ce_stb),
    .ce_addr  (ce_addr),
    .ce_syn   (ce_syn),
    .ue_stb   (ue_stb),
    .ue_addr  (ue_addr),
    .ue_syn   (ue_syn),
    .kind     (evt_kind),
    .addr_fld (evt_addr),
    .syn      (evt_syn)
  );

  ecc_ctrl_bits u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl)
  );

  ecc_record u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (evt_kind),
    .addr_fld (evt_addr),
    .syn      (evt_syn),
    .clr      (clr_req),
    .rec      (rec),
    .held     (rec_held),
    .capture  (rec_capture)
  );

  ecc_scrub_pulse u_scrub (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_stb    (ce_stb),
    .scrub_dis (ctrl.scrub_dis),
    .scrub_req (scrub_req)
  );

  assign rd_data  = pack_view(ctrl, rec);
  assign nmi_out  = rec.sbe & ctrl.nmi_en;
  assign serr_out = rec.mbe & ctrl.serr_en;

  always_comb begin
    if (rst_n) begin
      assert_nmi_level_R9: assert (nmi_out == (rd_data[BIT_SBE] & rd_data[BIT_NMI_EN]));
      assert_serr_level_R9: assert (serr_out == (rd_data[BIT_MBE] & rd_data[BIT_SERR_EN]));
    end
  end

  assert_capture_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_capture |=> (rd_data[BIT_SBE] | rd_data[BIT_MBE]));

  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0 && !scrub_req));

endmodule

// File: tb/tb_ecc_error_capture_reg.sv
module tb_ecc_error_capture_reg;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_stb = 1'b0, ue_stb = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] ce_addr = '0, ue_addr = '0;
  logic [7:0]    ce_syn = '0, ue_syn = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          nmi_out, serr_out, scrub_req;

  always #4 clk = ~clk;

  ecc_error_capture_reg #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .ce_stb(ce_stb), .ce_addr(ce_addr), .ce_syn(ce_syn),
    .ue_stb(ue_stb), .ue_addr(ue_addr), .ue_syn(ue_syn),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .nmi_out(nmi_out), .serr_out(serr_out),
    .scrub_req(scrub_req)
  );

  int errors = 0;
  int checks = 0;
  bit cmp_on = 0;
  bit done = 0;

  // behavioural model
  bit      m_sbe, m_mbe, m_sd, m_se, m_ne, m_scrub;
  longint  m_addr;
  int      m_syn;
  bit      t_clr, t_held, t_scrub;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sbe = 0; m_mbe = 0; m_sd = 0; m_se = 0; m_ne = 0; m_scrub = 0;
      m_addr = 0; m_syn = 0;
    end else begin
      t_clr   = wr_en && wr_data[0] && wr_data[1];
      t_held  = m_sbe || m_mbe;
      t_scrub = ce_stb && !m_sd;
      if (t_clr) begin
        m_sbe = 0; m_mbe = 0;
      end else if (!t_held) begin
        if (ue_stb) begin
          m_mbe = 1; m_addr = longint'(ue_addr) / 8192; m_syn = ue_syn;
        end else if (ce_stb) begin
          m_sbe = 1; m_addr = longint'(ce_addr) / 8192; m_syn = ce_syn;
        end
      end
      if (wr_en) begin
        m_sd = wr_data[31]; m_se = wr_data[3]; m_ne = wr_data[2];
      end
      m_scrub = t_scrub;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 control bits", {rd_data[31], rd_data[3], rd_data[2]}, {m_sd, m_se, m_ne});
      chk("R5/R7 status bits", rd_data[1:0], {m_mbe, m_sbe});
      chk("R6 address field", rd_data[30:12], m_addr % 524288);
      chk("R3 syndrome field", rd_data[11:4], m_syn);
      chk("R9 nmi level", nmi_out, m_sbe && m_ne);
      chk("R9 serr level", serr_out, m_mbe && m_se);
      chk("R10 scrub pulse", scrub_req, m_scrub);
    end
  end

  task automatic cyc(input bit ce, input logic [AW-1:0] ca, input logic [7:0] cs,
                     input bit ue, input logic [AW-1:0] ua, input logic [7:0] us,
                     input bit we, input logic [31:0] wd);
    @(negedge clk);
    #1;
    ce_stb = ce; ce_addr = ca; ce_syn = cs;
    ue_stb = ue; ue_addr = ua; ue_syn = us;
    wr_en = we; wr_data = wd;
    @(negedge clk);
    #1;
    ce_stb = 0; ue_stb = 0; wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, '0, '0, 0, '0, '0, 0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    cmp_on = 1;
    @(negedge clk);
    chk("R1 reset read", rd_data, 0);
    chk("R1 reset outputs", {nmi_out, serr_out, scrub_req}, 0);
    rst_n = 1;
    idle(2);

    // control write, read-only fields ignored
    cyc(0, '0, '0, 0, '0, '0, 1, 32'h7FFF_FFFC);
    chk("R2 directed write", rd_data, 32'h0000_000C);

    // first corrected error
    cyc(1, 32'hABCD_E123, 8'h5A, 0, '0, '0, 0, '0);
    chk("R3 directed capture", rd_data, {1'b0, 19'h55E6F, 8'h5A, 4'b1101});
    // later errors ignored
    cyc(0, '0, '0, 1, 32'h1234_5678, 8'hC3, 0, '0);
    cyc(1, 32'hFFFF_FFFF, 8'hFF, 0, '0, '0, 0, '0);
    chk("R6 directed frozen", rd_data[30:0], {19'h55E6F, 8'h5A, 4'b1101});

    // partial clears do nothing
    cyc(0, '0, '0, 0, '0, '0, 1, 32'h0000_000D);
    cyc(0, '0, '0, 0, '0, '0, 1, 32'h0000_000E);
    chk("R7 partial clear", rd_data[1:0], 2'b01);
    cyc(0, '0, '0, 0, '0, '0, 1, 32'h0000_000F);
    chk("R7 full clear", rd_data[1:0], 2'b00);

    // uncorrectable error
    cyc(0, '0, '0, 1, 32'h8000_2000, 8'h99, 0, '0);
    chk("R4 directed capture", rd_data, {1'b0, 19'h40001, 8'h99, 4'b1110});
    chk("R9 serr raised", serr_out, 1);

    // clear with simultaneous strobe: dropped, next one taken
    cyc(1, 32'h0000_4000, 8'h11, 0, '0, '0, 1, 32'h0000_000F);
    chk("R8 strobe during clear", rd_data[1:0], 2'b00);
    cyc(1, 32'h0000_4000, 8'h11, 0, '0, '0, 0, '0);
    chk("R8 strobe after clear", rd_data[1:0], 2'b01);
    cyc(0, '0, '0, 0, '0, '0, 1, 32'h0000_000F);

    // both strobes together
    cyc(1, 32'h1111_1111, 8'h22, 1, 32'hEEEE_EEEE, 8'h77, 0, '0);
    chk("R5 tie goes to multi-bit", rd_data[11:0], {8'h77, 4'b1110});
    cyc(0, '0, '0, 0, '0, '0, 1, 32'h0000_000F);

    // scrubbing: back-to-back, then disabled
    cyc(1, 32'h10, 8'h1, 0, '0, '0, 0, '0);
    cyc(1, 32'h20, 8'h2, 0, '0, '0, 0, '0);
    cyc(0, '0, '0, 0, '0, '0, 1, 32'h8000_000F);
    cyc(1, 32'h30, 8'h3, 0, '0, '0, 0, '0);
    chk("R10 scrub disabled", scrub_req, 0);
    cyc(0, '0, '0, 0, '0, '0, 1, 32'h0000_0003);

    // random phase
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      logic [31:0] wd;
      r  = $urandom;
      wd = $urandom;
      if (r[7:4] != 0) wd[1:0] = r[9:8] & 2'b01;
      cyc(r[0] & r[1], $urandom, r[23:16], r[2] & r[3] & r[10], $urandom, r[31:24],
          r[11] & r[12], wd);
    end

    idle(2);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule